// File: doc/BRIEF.md
# SPI Serial Memory Word Access Controller

This block sits on a host's simple synchronous register bus and lets the host move single 32-bit words to and from an external serial memory over SPI. The host loads a 16-bit memory address and, for a write, a 32-bit data word into registers. It then sets a start bit in a control register. The block assembles one 56-bit frame made of an 8-bit opcode, the 16-bit address and 32 data bits. It drives the frame out on the serial data line, most significant bit first, with chip select held low for the whole frame.

On a read, the block samples the last 32 bits of the frame from the memory's data output and stores them in the data register. The host polls a ready flag in the status register to learn when the transfer has finished. The serial clock rate is set by a divisor in a configuration register. Three read-only identification words let software recognise the block.

Top module: `spi_mem_ctrl`

## Requirements
- R1: Offsets 0x00, 0x01 and 0x02 always read 0x6D6B6D69, 0x66202020 and 0x302E3130. Host writes to these offsets have no effect.
- R2: Host reads return data combinationally in the same cycle that host_sel is high. The control offset 0x08 and every unmapped offset read zero.
- R3: After reset, status (0x09) bit 0 (ready) is 1, spi_csn is 1, spi_clk is 0, and the configuration register (0x0A) holds RESET_DIV.
- R4: Writing a value with bit 1 set to control (0x08) while ready starts a word write. With spi_csn low, the block sends exactly 56 bits MSB first on 56 rising spi_clk edges: opcode 0x02, then the 16-bit address register, then the 32-bit data register.
- R5: Writing a value with bit 0 set to control while ready starts a word read. The block sends opcode 0x03 and the address, then loads the 32 bits sampled on the last 32 rising edges, MSB first, into the data register (0x20). If bits 0 and 1 are both set, the read is performed.
- R6: The SPI link runs in mode 0. spi_clk is low whenever spi_csn is high, and spi_mosi never changes on a rising spi_clk edge.
- R7: Each spi_clk half period lasts D host clock cycles, where D is the low 16 bits of the configuration register. A value of 0 is treated as 1.
- R8: Ready falls at the clock edge that starts a transfer. It rises again at the same edge that releases spi_csn, and it is never high while spi_csn is low.
- R9: A control write made while ready is low, or with neither bit 0 nor bit 1 set, starts no transfer.
- R10: The address register (0x10) keeps the low 16 bits of a host write and reads back zero-extended. The data register (0x20) is a full 32-bit read/write register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_sel | input | 1 | Register access select |
| host_wr | input | 1 | Write enable for the selected access |
| host_addr | input | 8 | Register offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, valid while host_sel is high |
| spi_clk | output | 1 | Serial clock to the memory |
| spi_csn | output | 1 | Active-low memory chip select |
| spi_mosi | output | 1 | Serial data to the memory |
| spi_miso | input | 1 | Serial data from the memory |

## Verification
The bench builds the block with its default parameters: a 16-bit address, a 16-bit divisor field and a slow reset divisor of 32. It reprograms the divisor at run time to 2 and to 0, so several full 56-bit frames fit in a short run, and the zero-means-one rule is exercised. A small behavioural serial memory in the bench stores written words and serves them back. A write followed by a read therefore checks frame layout, bit order, sampling edge and data capture together.

// File: rtl/smc_pkg.sv
package smc_pkg;
  localparam int HOST_W = 32;
  localparam int OPC_W  = 8;

  localparam logic [7:0] OFF_ID_A   = 8'h00;
  localparam logic [7:0] OFF_ID_B   = 8'h01;
  localparam logic [7:0] OFF_REV    = 8'h02;
  localparam logic [7:0] OFF_CTRL   = 8'h08;
  localparam logic [7:0] OFF_STAT   = 8'h09;
  localparam logic [7:0] OFF_CFG    = 8'h0A;
  localparam logic [7:0] OFF_MADDR  = 8'h10;
  localparam logic [7:0] OFF_MDATA  = 8'h20;

  localparam logic [HOST_W-1:0] ID_A_WORD = 32'h6D6B_6D69;
  localparam logic [HOST_W-1:0] ID_B_WORD = 32'h6620_2020;
  localparam logic [HOST_W-1:0] REV_WORD  = 32'h302E_3130;

  localparam logic [OPC_W-1:0] OPC_WRITE = 8'h02;
  localparam logic [OPC_W-1:0] OPC_READ  = 8'h03;

  localparam int CTRL_RD_BIT = 0;
  localparam int CTRL_WR_BIT = 1;
endpackage

// File: rtl/smc_spi_engine.sv
module smc_spi_engine #(
  parameter int FRAME_W = 56,
  parameter int DIV_W   = 16,
  parameter int RX_W    = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [FRAME_W-1:0] frame,
  input  logic [DIV_W-1:0]   div,
  input  logic               spi_miso,
  output logic               spi_clk,
  output logic               spi_csn,
  output logic               spi_mosi,
  output logic               done,
  output logic [RX_W-1:0]    rx_word
);
  localparam int CNT_W = $clog2(FRAME_W + 1);

  function automatic logic [DIV_W-1:0] half_len(input logic [DIV_W-1:0] d);
    return (d == '0) ? DIV_W'(1) : d;
  endfunction

  logic               busy;
  logic [FRAME_W-1:0] sh;
  logic [DIV_W-1:0]   div_q;
  logic [DIV_W-1:0]   ctr;
  logic [CNT_W-1:0]   bits;
  logic               samp;

  // named internal events
  logic tick, rise_ev, fall_ev, last_bit;
  assign tick     = busy && (ctr == half_len(div_q) - DIV_W'(1));
  assign rise_ev  = tick && !spi_clk;
  assign fall_ev  = tick && spi_clk;
  assign last_bit = (bits == CNT_W'(FRAME_W - 1));

  assign done     = fall_ev && last_bit;
  assign rx_word  = {sh[RX_W-2:0], samp};
  assign spi_mosi = busy & sh[FRAME_W-1];
  assign spi_csn  = ~busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      sh      <= '0;
      div_q   <= '0;
      ctr     <= '0;
      bits    <= '0;
      samp    <= 1'b0;
      spi_clk <= 1'b0;
    end else if (start && !busy) begin
      busy    <= 1'b1;
      sh      <= frame;
      div_q   <= div;
      ctr     <= '0;
      bits    <= '0;
      spi_clk <= 1'b0;
    end else if (busy) begin
      ctr <= tick ? '0 : ctr + DIV_W'(1);
      if (rise_ev) begin
        spi_clk <= 1'b1;
        samp    <= spi_miso;
      end
      if (fall_ev) begin
        spi_clk <= 1'b0;
        sh      <= {sh[FRAME_W-2:0], samp};
        bits    <= bits + CNT_W'(1);
        if (last_bit) busy <= 1'b0;
      end
    end
  end

  assert_mosi_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $rose(spi_clk)) |-> $stable(spi_mosi));
  assert_sclk_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    spi_csn |-> !spi_clk);
  assert_half_period_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (ctr < half_len(div_q)));
  assert_bit_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (bits < CNT_W'(FRAME_W)));
  assert_done_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> spi_csn);
endmodule

// File: rtl/smc_regs.sv
module smc_regs
  import smc_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter int          DIV_W     = 16,
  parameter logic [15:0] RESET_DIV = 16'd32,
  localparam int         FRAME_W   = OPC_W + ADDR_W + HOST_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_sel,
  input  logic               host_wr,
  input  logic [7:0]         host_addr,
  input  logic [HOST_W-1:0]  host_wdata,
  output logic [HOST_W-1:0]  host_rdata,
  input  logic               eng_done,
  input  logic [HOST_W-1:0]  rx_word,
  output logic               start,
  output logic [FRAME_W-1:0] frame,
  output logic [DIV_W-1:0]   div,
  output logic               ready
);
  function automatic logic [FRAME_W-1:0] make_frame(input logic is_rd,
      input logic [ADDR_W-1:0] a, input logic [HOST_W-1:0] d);
    return is_rd ? {OPC_READ, a, {HOST_W{1'b0}}} : {OPC_WRITE, a, d};
  endfunction

  logic [ADDR_W-1:0] maddr;
  logic [HOST_W-1:0] mdata;
  logic              do_wr, ctrl_wr, want_rd, want_wr;

  assign do_wr   = host_sel && host_wr;
  assign ctrl_wr = do_wr && (host_addr == OFF_CTRL);
  assign want_rd = host_wdata[CTRL_RD_BIT];
  assign want_wr = host_wdata[CTRL_WR_BIT];
  assign start   = ctrl_wr && ready && (want_rd || want_wr);
  assign frame   = make_frame(want_rd, maddr, mdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      maddr <= '0;
      mdata <= '0;
      div   <= DIV_W'(RESET_DIV);
      ready <= 1'b1;
    end else begin
      if (do_wr && host_addr == OFF_MADDR) maddr <= host_wdata[ADDR_W-1:0];
      if (do_wr && host_addr == OFF_CFG)   div   <= host_wdata[DIV_W-1:0];
      if (start)
        ready <= 1'b0;
      else if (eng_done)
        ready <= 1'b1;
      if (eng_done && frame_is_read_q)
        mdata <= rx_word;
      else if (do_wr && host_addr == OFF_MDATA)
        mdata <= host_wdata;
    end
  end

  logic frame_is_read_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     frame_is_read_q <= 1'b0;
    else if (start) frame_is_read_q <= want_rd;
  end

  always_comb begin
    host_rdata = '0;
    if (host_sel) begin
      unique case (host_addr)
        OFF_ID_A:  host_rdata = ID_A_WORD;
        OFF_ID_B:  host_rdata = ID_B_WORD;
        OFF_REV:   host_rdata = REV_WORD;
        OFF_STAT:  host_rdata = {{(HOST_W-1){1'b0}}, ready};
        OFF_CFG:   host_rdata = {{(HOST_W-DIV_W){1'b0}}, div};
        OFF_MADDR: host_rdata = {{(HOST_W-ADDR_W){1'b0}}, maddr};
        OFF_MDATA: host_rdata = mdata;
        default:   host_rdata = '0;
      endcase
    end
  end

  assert_start_clears_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !ready);
  assert_busy_ctrl_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !ready && !eng_done) |=> !ready);
endmodule

// File: rtl/spi_mem_ctrl.sv
module spi_mem_ctrl
  import smc_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter int          DIV_W     = 16,
  parameter logic [15:0] RESET_DIV = 16'd32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_sel,
  input  logic        host_wr,
  input  logic [7:0]  host_addr,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  output logic        spi_clk,
  output logic        spi_csn,
  output logic        spi_mosi,
  input  logic        spi_miso
);
  localparam int FRAME_W = OPC_W + ADDR_W + HOST_W;

  logic               start, done, ready;
  logic [FRAME_W-1:0] frame;
  logic [DIV_W-1:0]   div;
  logic [HOST_W-1:0]  rx_word;

  smc_regs #(.ADDR_W(ADDR_W), .DIV_W(DIV_W), .RESET_DIV(RESET_DIV)) u_regs (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .eng_done(done), .rx_word(rx_word), .start(start), .frame(frame),
    .div(div), .ready(ready)
  );

  smc_spi_engine #(.FRAME_W(FRAME_W), .DIV_W(DIV_W), .RX_W(HOST_W)) u_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .frame(frame), .div(div),
    .spi_miso(spi_miso), .spi_clk(spi_clk), .spi_csn(spi_csn),
    .spi_mosi(spi_mosi), .done(done), .rx_word(rx_word)
  );

  assert_ready_vs_select_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_csn |-> !ready);
  assert_release_sets_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_csn) |-> ready);
endmodule

// File: tb/spi_mem_ctrl_tb.sv
`timescale 1ns/100ps
module spi_mem_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_sel = 1'b0, host_wr = 1'b0;
  logic [7:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        spi_clk, spi_csn, spi_mosi;
  logic        spi_miso = 1'b0;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  spi_mem_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .spi_clk(spi_clk), .spi_csn(spi_csn), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  // ---------------- behavioural serial memory ----------------
  logic [31:0] mem [0:15];
  logic [55:0] mon_frame, last_frame;
  int          mon_cnt = 0, last_cnt = 0, frames = 0;
  realtime     rise0, rise1, last_half;
  logic [31:0] ret_q;

  initial for (int i = 0; i < 16; i++) mem[i] = 32'hC0DE_0000 + i;

  always @(negedge spi_csn) begin
    mon_cnt = 0;
    mon_frame = '0;
  end

  always @(posedge spi_clk) begin
    if (!spi_csn) begin
      if (mon_cnt == 0) rise0 = $realtime;
      if (mon_cnt == 1) rise1 = $realtime;
      mon_frame = {mon_frame[54:0], spi_mosi};
      mon_cnt++;
    end
  end

  always @(negedge spi_clk) begin
    if (!spi_csn && mon_cnt >= 24 && mon_cnt < 56) begin
      if (mon_cnt == 24) begin
        ret_q = mem[mon_frame[3:0]];
      end
      spi_miso <= ret_q[55 - mon_cnt];
    end
  end

  always @(posedge spi_csn) begin
    if (rst_n) begin
      frames++;
      last_frame = mon_frame;
      last_cnt   = mon_cnt;
      last_half  = (rise1 - rise0) / 2.0;
      if (mon_cnt == 56 && mon_frame[55:48] == 8'h02)
        mem[mon_frame[35:32]] = mon_frame[31:0];
      spi_miso <= 1'b0;
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic host_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    host_sel = 1; host_wr = 1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_sel = 0; host_wr = 0;
  endtask

  task automatic host_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    host_sel = 1; host_wr = 0; host_addr = a;
    #1 d = host_rdata;
    @(negedge clk);
    host_sel = 0;
  endtask

  task automatic wait_ready(input string req);
    logic [31:0] s;
    int n = 0;
    s = 0;
    while (s[0] !== 1'b1 && n < 20000) begin
      host_read(8'h09, s);
      n++;
    end
    check(req, "ready returns after transfer", {63'd0, s[0]}, 64'd1);
  endtask

  // wr, offset, wdata, expected read
  localparam int NV = 13;
  localparam logic [72:0] VEC [0:NV-1] = '{
    {1'b0, 8'h00, 32'h0, 32'h6D6B6D69},  // R1 id word A
    {1'b0, 8'h01, 32'h0, 32'h66202020},  // R1 id word B
    {1'b0, 8'h02, 32'h0, 32'h302E3130},  // R1 revision
    {1'b0, 8'h03, 32'h0, 32'h0},         // R2 unmapped
    {1'b0, 8'h30, 32'h0, 32'h0},         // R2 unmapped
    {1'b0, 8'h08, 32'h0, 32'h0},         // R2 control reads zero
    {1'b0, 8'h09, 32'h0, 32'h1},         // R3 ready after reset
    {1'b0, 8'h0A, 32'h0, 32'h20},        // R3 reset divisor
    {1'b1, 8'h10, 32'hABCD1234, 32'h0},  // R10 address write
    {1'b0, 8'h10, 32'h0, 32'h1234},      // R10 truncated readback
    {1'b1, 8'h20, 32'hCAFEF00D, 32'h0},  // R10 data write
    {1'b0, 8'h20, 32'h0, 32'hCAFEF00D},  // R10 data readback
    {1'b1, 8'h01, 32'h55555555, 32'h0}   // R1 write to id ignored
  };

  logic [31:0] rd;
  int f0;

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R3 reset state of the serial pins
    check("R3", "csn idle", {63'd0, spi_csn}, 64'd1);
    check("R3", "sclk idle", {63'd0, spi_clk}, 64'd0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][72]) host_write(VEC[i][71:64], VEC[i][63:32]);
      else begin
        host_read(VEC[i][71:64], rd);
        check("R1/R2/R3/R10 table", $sformatf("entry %0d", i), {32'd0, rd}, {32'd0, VEC[i][31:0]});
      end
    end
    host_read(8'h01, rd);
    check("R1", "id word after write", {32'd0, rd}, 64'h66202020);

    // R4 word write with divisor 2
    host_write(8'h0A, 32'd2);
    host_write(8'h10, 32'h0005);
    host_write(8'h20, 32'hDEADBEEF);
    f0 = frames;
    host_write(8'h08, 32'h2);
    host_read(8'h09, rd);
    check("R8", "ready low while busy", {32'd0, rd}, 64'd0);
    host_write(8'h08, 32'h1);  // R9 ignored while busy
    wait_ready("R8");
    repeat (300) @(negedge clk);
    check("R9", "one frame only", 64'(frames - f0), 64'd1);
    check("R4", "frame content", {8'd0, last_frame}, {8'd0, 8'h02, 16'h0005, 32'hDEADBEEF});
    check("R4", "edge count", 64'(last_cnt), 64'd56);
    check("R7", "half period div 2", 64'(int'(last_half * 10)), 64'd100);
    check("R4", "memory stored", {32'd0, mem[5]}, 64'hDEADBEEF);
    host_read(8'h20, rd);
    check("R10", "data kept after write", {32'd0, rd}, 64'hDEADBEEF);

    // R5 word read round trip
    host_write(8'h20, 32'h0);
    host_write(8'h08, 32'h1);
    wait_ready("R5");
    check("R5", "read opcode and address", {40'd0, last_frame[55:32]}, {40'd0, 8'h03, 16'h0005});
    host_read(8'h20, rd);
    check("R5", "captured word", {32'd0, rd}, 64'hDEADBEEF);

    // R5 both bits set: read wins, preloaded word
    host_write(8'h10, 32'h0003);
    host_write(8'h08, 32'h3);
    wait_ready("R5");
    host_read(8'h20, rd);
    check("R5", "read with both bits", {32'd0, rd}, 64'hC0DE0003);
    check("R6", "mem untouched", {32'd0, mem[3]}, 64'hC0DE0003);

    // R7 divisor zero acts as one
    host_write(8'h0A, 32'd0);
    host_write(8'h10, 32'h0007);
    host_write(8'h20, 32'h12345678);
    host_write(8'h08, 32'h2);
    wait_ready("R7");
    check("R7", "half period div 0", 64'(int'(last_half * 10)), 64'd50);
    host_write(8'h20, 32'h0);
    host_write(8'h08, 32'h1);
    wait_ready("R6");
    host_read(8'h20, rd);
    check("R6", "mode 0 round trip", {32'd0, rd}, 64'h12345678);

    // R9 control write without start bits
    f0 = frames;
    host_write(8'h08, 32'h4);
    host_read(8'h09, rd);
    check("R9", "ready stays high", {32'd0, rd}, 64'd1);
    repeat (50) @(negedge clk);
    check("R9", "no frame started", 64'(frames - f0), 64'd0);
    check("R9", "csn still high", {63'd0, spi_csn}, 64'd1);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule